// File: doc/BRIEF.md
# Multichannel DAC Serial Register Interface

This block is the digital control side of a multichannel digital-to-analog converter. It acts as an SPI slave and receives 24-bit frames MSB first while chip select is low. Each frame carries a 2-bit command, a 6-bit address and a 16-bit data word. The block keeps three registers per channel: an output code, an offset trim and a gain trim. A separate special-function space holds a control word, a small set of per-group offset registers and a readback selector. A host reads a register by first sending a readback request. It then sends one more frame, and the requested value comes back on MISO during that frame.

The serial pins are oversampled by the system clock. Every register value is exposed on a port so the analog side of the chip can use it directly. One of those ports gives each channel the offset of the reference group it belongs to. Channel count, group size, group count and code resolution are parameters.

Top module: `mcdac_regif`

## Requirements
- R1: A frame is committed on the 24th rising SCLK edge seen while CS_N is low. The first bit received is bit 23. Bits 23:22 are the command, bits 21:16 the address and bits 15:0 the data.
- R2: Command 3 writes the channel code register, command 2 the channel offset trim and command 1 the channel gain trim. The channel written is the one at address minus 8, for addresses 0x08 up to 0x08+NCH-1.
- R3: Channel registers keep only the upper CODE_BITS bits of the data word, and the lower bits are stored as zero. With the default CODE_BITS of 14, a written value is ANDed with 0xFFFC.
- R4: Command 0 to address 0x01 writes the 16-bit control word. Bit 0 of the control word drives pwr_down_o.
- R5: Command 0 to address 0x02+g, for g below NGRP, writes group offset g from data bits 13:0.
- R6: The ch_ofs_o slice of channel c equals group offset min(c/GSIZE, NGRP-1).
- R7: Command 0 to address 0x05 arms a readback. Data bits 15:13 give the kind and bits 12:7 the address. In the next CS_N frame, MISO shifts out 24 bits MSB first: 8 zeros, then the 16-bit value. The first bit is valid after CS_N falls, and the bit advances on each falling SCLK edge. The kinds are: 0 and 1 return the channel code, 2 the offset trim, 3 the gain trim. Kind 4 selects the special space: address 1 gives the control word, 0x02+g gives group offset g zero-extended, and 5 gives the selector as {kind,address,7'b0}. Anything unmapped reads 0.
- R8: The frame that carries a readback reply is not decoded, and its MOSI content changes no register.
- R9: Writes to unmapped addresses change no register. This covers channel addresses outside the range, special addresses 0x00 and 0x06 to 0x3F, and group addresses at or beyond NGRP.
- R10: A frame ended by CS_N rising before 24 bits is discarded. The next frame starts counting from bit 23 again.
- R11: Reset is synchronous and active high. After reset, code and offset trims are 0, gain trims have all code bits set (0xFFFC), and control and group offsets are 0. The selector points at kind 0, address 0x08, and no reply is pending. MISO is 0 during any frame that is not a reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| code_o | output | NCH*16 | Channel code registers, channel c at [16c+15:16c] |
| ofs_o | output | NCH*16 | Channel offset trims |
| gain_o | output | NCH*16 | Channel gain trims |
| grp_ofs_o | output | NGRP*14 | Group offset registers |
| ch_ofs_o | output | NCH*14 | Group offset in effect for each channel |
| pwr_down_o | output | 1 | Global power-down, control bit 0 |

## Verification
A vector table writes each register kind and then reads it back through a request and reply pair. This shows that command, address and readback kind are all decoded independently. Data patterns with the low two bits set show the truncation to code width. Groups hold distinct values, so the group offset port can tell ordinary group membership apart from clamping to the last group. Directed frames then send writes to unmapped addresses, a truncated frame and a reply frame that carries a write. In each case all register ports must stay unchanged.

// File: rtl/mcdac_pkg.sv
package mcdac_pkg;

    localparam int FRAME_W = 24;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 6;
    localparam int GOFS_W  = 14;

    localparam logic [ADDR_W-1:0] CH_BASE   = 6'h08;
    localparam logic [ADDR_W-1:0] SF_CTRL   = 6'h01;
    localparam logic [ADDR_W-1:0] SF_GOFS0  = 6'h02;
    localparam logic [ADDR_W-1:0] SF_RBREQ  = 6'h05;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'd0,
        OP_GAIN    = 2'd1,
        OP_OFFSET  = 2'd2,
        OP_CODE    = 2'd3
    } op_e;

    localparam logic [2:0] RB_CODE     = 3'd0;
    localparam logic [2:0] RB_CODE_ALT = 3'd1;
    localparam logic [2:0] RB_OFFSET   = 3'd2;
    localparam logic [2:0] RB_GAIN     = 3'd3;
    localparam logic [2:0] RB_SPECIAL  = 3'd4;

    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  data;
    } frame_t;

    typedef struct packed {
        logic [2:0]         kind;
        logic [ADDR_W-1:0]  addr;
    } rbsel_t;

    typedef struct packed {
        logic               code_we;
        logic               ofs_we;
        logic               gain_we;
        logic               ctrl_we;
        logic               gofs_we;
        logic               rb_we;
        logic [ADDR_W-1:0]  idx;
        logic [WORD_W-1:0]  data;
    } wr_t;

    function automatic int group_of(input int ch, input int gsize, input int ngrp);
        int g;
        g = ch / gsize;
        if (g >= ngrp) g = ngrp - 1;
        return g;
    endfunction

endpackage

// File: rtl/mcdac_link.sv
module mcdac_link
    import mcdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              reply_pend,
    input  logic [WORD_W-1:0] reply_word,
    output logic              miso,
    output logic              frame_ok,
    output frame_t            frame,
    output logic              reply_start
);

    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic [2:0]         sclk_sr;
    logic [2:0]         cs_sr;
    logic [1:0]         mosi_sr;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_q;
    logic               in_reply;

    logic sclk_rise, sclk_fall, cs_low, cs_fall, mosi_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
        end else begin
            sclk_sr <= {sclk_sr[1:0], sclk};
            cs_sr   <= {cs_sr[1:0], cs_n};
            mosi_sr <= {mosi_sr[0], mosi};
        end
    end

    assign sclk_rise   = sclk_sr[1] & ~sclk_sr[2];
    assign sclk_fall   = ~sclk_sr[1] & sclk_sr[2];
    assign cs_low      = ~cs_sr[1];
    assign cs_fall     = ~cs_sr[1] & cs_sr[2];
    assign mosi_s      = mosi_sr[1];
    assign reply_start = cs_fall & reply_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            rx_sr    <= '0;
            tx_q     <= '0;
            in_reply <= 1'b0;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= 1'b0;
            if (!cs_low) begin
                cnt      <= '0;
                in_reply <= 1'b0;
            end else if (cs_fall) begin
                cnt      <= '0;
                in_reply <= reply_pend;
                tx_q     <= reply_pend ? {{(FRAME_W-WORD_W){1'b0}}, reply_word} : '0;
            end else begin
                if (sclk_rise && cnt != CNT_W'(FRAME_W)) begin
                    rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CNT_W'(FRAME_W - 1) && !in_reply)
                        frame_ok <= 1'b1;
                end
                if (sclk_fall)
                    tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign frame = frame_t'(rx_sr);
    assign miso  = tx_q[FRAME_W-1];

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W));

    // R8
    frame_cs_chk: assert property (@(posedge clk) disable iff (rst)
        frame_ok |-> ($past(cs_low) && !$past(in_reply)));

    // R11
    quiet_miso_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_low && !cs_fall && !in_reply) |-> (tx_q == '0));

endmodule

// File: rtl/mcdac_decode.sv
module mcdac_decode
    import mcdac_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NGRP = 3
) (
    input  logic   frame_ok,
    input  frame_t frame,
    output wr_t    wr
);

    logic ch_hit, grp_hit;

    always_comb begin
        ch_hit  = (frame.addr >= CH_BASE) &&
                  (32'(frame.addr) < 32'(CH_BASE) + 32'(NCH));
        grp_hit = (frame.addr >= SF_GOFS0) &&
                  (32'(frame.addr) < 32'(SF_GOFS0) + 32'(NGRP));

        wr         = '0;
        wr.data    = frame.data;
        wr.idx     = frame.addr - CH_BASE;
        if (frame_ok) begin
            unique case (frame.op)
                OP_CODE:   wr.code_we = ch_hit;
                OP_OFFSET: wr.ofs_we  = ch_hit;
                OP_GAIN:   wr.gain_we = ch_hit;
                OP_SPECIAL: begin
                    if (frame.addr == SF_CTRL) begin
                        wr.ctrl_we = 1'b1;
                    end else if (grp_hit) begin
                        wr.gofs_we = 1'b1;
                        wr.idx     = frame.addr - SF_GOFS0;
                    end else if (frame.addr == SF_RBREQ) begin
                        wr.rb_we = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mcdac_regbank.sv
module mcdac_regbank
    import mcdac_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int GSIZE     = 4,
    parameter int NGRP      = 3,
    parameter int CODE_BITS = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_t                      wr,
    input  logic                     reply_start,
    output logic [NCH*WORD_W-1:0]    code_o,
    output logic [NCH*WORD_W-1:0]    ofs_o,
    output logic [NCH*WORD_W-1:0]    gain_o,
    output logic [NGRP*GOFS_W-1:0]   grp_ofs_o,
    output logic [NCH*GOFS_W-1:0]    ch_ofs_o,
    output logic                     pwr_down_o,
    output logic                     reply_pend,
    output logic [WORD_W-1:0]        reply_word
);

    localparam logic [WORD_W-1:0] KEEP =
        WORD_W'(~((32'd1 << (WORD_W - CODE_BITS)) - 32'd1));

    logic [WORD_W-1:0] code_q [NCH];
    logic [WORD_W-1:0] ofs_q  [NCH];
    logic [WORD_W-1:0] gain_q [NCH];
    logic [GOFS_W-1:0] gofs_q [NGRP];
    logic [WORD_W-1:0] ctrl_q;
    rbsel_t            sel_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GRP = group_of(c, GSIZE, NGRP);
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[c] <= '0;
                ofs_q[c]  <= '0;
                gain_q[c] <= KEEP;
            end else if (wr.idx == ADDR_W'(c)) begin
                if (wr.code_we) code_q[c] <= wr.data & KEEP;
                if (wr.ofs_we)  ofs_q[c]  <= wr.data & KEEP;
                if (wr.gain_we) gain_q[c] <= wr.data & KEEP;
            end
        end
        assign code_o[c*WORD_W +: WORD_W]   = code_q[c];
        assign ofs_o[c*WORD_W +: WORD_W]    = ofs_q[c];
        assign gain_o[c*WORD_W +: WORD_W]   = gain_q[c];
        assign ch_ofs_o[c*GOFS_W +: GOFS_W] = gofs_q[GRP];
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst)
                gofs_q[g] <= '0;
            else if (wr.gofs_we && wr.idx == ADDR_W'(g))
                gofs_q[g] <= wr.data[GOFS_W-1:0];
        end
        assign grp_ofs_o[g*GOFS_W +: GOFS_W] = gofs_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            sel_q      <= '{kind: RB_CODE, addr: CH_BASE};
            reply_pend <= 1'b0;
        end else begin
            if (wr.ctrl_we)
                ctrl_q <= wr.data;
            if (wr.rb_we) begin
                sel_q      <= rbsel_t'(wr.data[WORD_W-1 -: 9]);
                reply_pend <= 1'b1;
            end else if (reply_start) begin
                reply_pend <= 1'b0;
            end
        end
    end

    assign pwr_down_o = ctrl_q[0];

    always_comb begin
        reply_word = '0;
        unique case (sel_q.kind)
            RB_CODE, RB_CODE_ALT, RB_OFFSET, RB_GAIN: begin
                for (int c = 0; c < NCH; c++) begin
                    if (32'(sel_q.addr) == 32'(CH_BASE) + 32'(c)) begin
                        if (sel_q.kind == RB_OFFSET)     reply_word = ofs_q[c];
                        else if (sel_q.kind == RB_GAIN)  reply_word = gain_q[c];
                        else                             reply_word = code_q[c];
                    end
                end
            end
            RB_SPECIAL: begin
                if (sel_q.addr == SF_CTRL)
                    reply_word = ctrl_q;
                else if (sel_q.addr == SF_RBREQ)
                    reply_word = {sel_q, 7'b0};
                for (int g = 0; g < NGRP; g++) begin
                    if (32'(sel_q.addr) == 32'(SF_GOFS0) + 32'(g))
                        reply_word = {{(WORD_W-GOFS_W){1'b0}}, gofs_q[g]};
                end
            end
            default: reply_word = '0;
        endcase
    end

    // R4
    pd_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pwr_down_o) |-> $past(wr.ctrl_we));

    // R7
    sel_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> $past(wr.rb_we));

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(reply_pend) |-> $past(reply_start));

endmodule

// File: rtl/mcdac_regif.sv
module mcdac_regif
    import mcdac_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int GSIZE     = 4,
    parameter int NGRP      = 3,
    parameter int CODE_BITS = 14
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   spi_sclk,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic [NCH*16-1:0]      code_o,
    output logic [NCH*16-1:0]      ofs_o,
    output logic [NCH*16-1:0]      gain_o,
    output logic [NGRP*14-1:0]     grp_ofs_o,
    output logic [NCH*14-1:0]      ch_ofs_o,
    output logic                   pwr_down_o
);

    logic              frame_ok;
    frame_t            frame;
    logic              reply_start;
    logic              reply_pend;
    logic [WORD_W-1:0] reply_word;
    wr_t               wr;

    mcdac_link u_link (
        .clk         (clk),
        .rst         (rst),
        .sclk        (spi_sclk),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi),
        .reply_pend  (reply_pend),
        .reply_word  (reply_word),
        .miso        (spi_miso),
        .frame_ok    (frame_ok),
        .frame       (frame),
        .reply_start (reply_start)
    );

    mcdac_decode #(.NCH(NCH), .NGRP(NGRP)) u_decode (
        .frame_ok (frame_ok),
        .frame    (frame),
        .wr       (wr)
    );

    mcdac_regbank #(
        .NCH(NCH), .GSIZE(GSIZE), .NGRP(NGRP), .CODE_BITS(CODE_BITS)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .reply_start (reply_start),
        .code_o      (code_o),
        .ofs_o       (ofs_o),
        .gain_o      (gain_o),
        .grp_ofs_o   (grp_ofs_o),
        .ch_ofs_o    (ch_ofs_o),
        .pwr_down_o  (pwr_down_o),
        .reply_pend  (reply_pend),
        .reply_word  (reply_word)
    );

endmodule

// File: tb/mcdac_regif_test.sv
module mcdac_regif_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 16;
    localparam int NGRP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [NCH*16-1:0]  code_o, ofs_o, gain_o;
    logic [NGRP*14-1:0] grp_ofs_o;
    logic [NCH*14-1:0]  ch_ofs_o;
    logic               pwr_down_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcdac_regif #(.NCH(NCH), .GSIZE(4), .NGRP(NGRP), .CODE_BITS(14)) uut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .code_o(code_o), .ofs_o(ofs_o), .gain_o(gain_o),
        .grp_ofs_o(grp_ofs_o), .ch_ofs_o(ch_ofs_o), .pwr_down_o(pwr_down_o)
    );

    // {write frame, readback kind, readback address, expected reply}
    localparam logic [48:0] VEC [11] = '{
        {24'hC81234, 3'd0, 6'h08, 16'h1234},
        {24'hD7ABCF, 3'd0, 6'h17, 16'hABCC},
        {24'h8B5555, 3'd2, 6'h0B, 16'h5554},
        {24'h4F0F0F, 3'd3, 6'h0F, 16'h0F0C},
        {24'h010001, 3'd4, 6'h01, 16'h0001},
        {24'h02FFFF, 3'd4, 6'h02, 16'h3FFF},
        {24'h030077, 3'd4, 6'h03, 16'h0077},
        {24'h040123, 3'd4, 6'h04, 16'h0123},
        {24'hC88888, 3'd1, 6'h08, 16'h8888},
        {24'h000000, 3'd5, 6'h08, 16'h0000},
        {24'h000000, 3'd4, 6'h05, 16'h8280}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input logic [23:0] tx, input int nbits,
                             output logic [23:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 23; i > 23 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(4);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    function automatic logic [23:0] rb_req(input logic [2:0] k, input logic [5:0] a);
        return {2'b00, 6'h05, k, a, 7'b0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [23:0] rx;
        logic [NCH*16-1:0] s_code, s_ofs, s_gain, exp_gain;
        logic [NGRP*14-1:0] s_grp;
        logic s_pd;

        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);

        // R11 reset state at the ports
        for (int c = 0; c < NCH; c++) exp_gain[c*16 +: 16] = 16'hFFFC;
        check(code_o == '0 && ofs_o == '0, "R11 code/offset reset", code_o ^ ofs_o, 0);
        check(gain_o == exp_gain, "R11 gain reset", gain_o, exp_gain);
        check(pwr_down_o == 1'b0 && grp_ofs_o == '0, "R11 control/group reset",
              {pwr_down_o, grp_ofs_o}, 0);
        spi_frame(24'h000000, 24, rx);
        check(rx == 24'h0, "R11 miso quiet with no reply pending", rx, 0);
        spi_frame(rb_req(3'd3, 6'h0D), 24, rx);
        spi_frame(24'h000000, 24, rx);
        check(rx == 24'h00FFFC, "R11 gain reset readback", rx, 24'h00FFFC);

        // R1 R2 R3 R4 R5 R7 table: write, request, reply
        foreach (VEC[i]) begin
            spi_frame(VEC[i][48:25], 24, rx);
            spi_frame(rb_req(VEC[i][24:22], VEC[i][21:16]), 24, rx);
            spi_frame(24'h000000, 24, rx);
            check(rx == {8'h00, VEC[i][15:0]}, $sformatf("R7 R1 vector %0d readback", i),
                  rx, {8'h00, VEC[i][15:0]});
        end

        // R2 R3 at the ports
        check(code_o[0*16 +: 16] == 16'h8888, "R2 ch0 code", code_o[0 +: 16], 16'h8888);
        check(code_o[15*16 +: 16] == 16'hABCC, "R3 ch15 code truncated",
              code_o[15*16 +: 16], 16'hABCC);
        check(ofs_o[3*16 +: 16] == 16'h5554, "R2 ch3 offset", ofs_o[3*16 +: 16], 16'h5554);
        check(gain_o[7*16 +: 16] == 16'h0F0C, "R2 ch7 gain", gain_o[7*16 +: 16], 16'h0F0C);
        // R4
        check(pwr_down_o == 1'b1, "R4 power-down set", pwr_down_o, 1);
        // R5
        check(grp_ofs_o == {14'h0123, 14'h0077, 14'h3FFF}, "R5 group offsets",
              grp_ofs_o, {14'h0123, 14'h0077, 14'h3FFF});
        // R6 group membership and clamping
        check(ch_ofs_o[3*14 +: 14] == 14'h3FFF, "R6 ch3 group0", ch_ofs_o[3*14 +: 14], 14'h3FFF);
        check(ch_ofs_o[4*14 +: 14] == 14'h0077, "R6 ch4 group1", ch_ofs_o[4*14 +: 14], 14'h0077);
        check(ch_ofs_o[7*14 +: 14] == 14'h0077, "R6 ch7 group1", ch_ofs_o[7*14 +: 14], 14'h0077);
        check(ch_ofs_o[8*14 +: 14] == 14'h0123, "R6 ch8 group2", ch_ofs_o[8*14 +: 14], 14'h0123);
        check(ch_ofs_o[15*14 +: 14] == 14'h0123, "R6 ch15 clamped", ch_ofs_o[15*14 +: 14], 14'h0123);

        spi_frame(24'h010000, 24, rx);
        check(pwr_down_o == 1'b0, "R4 power-down cleared", pwr_down_o, 0);

        // R9 unmapped and no-op writes
        s_code = code_o; s_ofs = ofs_o; s_gain = gain_o; s_grp = grp_ofs_o; s_pd = pwr_down_o;
        spi_frame(24'hF0FFFF, 24, rx);
        spi_frame(24'h82FFFF, 24, rx);
        spi_frame(24'h58FFFF, 24, rx);
        spi_frame(24'h00FFFF, 24, rx);
        spi_frame(24'h06FFFF, 24, rx);
        spi_frame(24'h3FFFFF, 24, rx);
        check(code_o == s_code && ofs_o == s_ofs && gain_o == s_gain,
              "R9 channel registers unchanged", code_o ^ s_code ^ ofs_o ^ s_ofs, 0);
        check(grp_ofs_o == s_grp && pwr_down_o == s_pd, "R9 special registers unchanged",
              {grp_ofs_o, pwr_down_o}, {s_grp, s_pd});

        // R10 truncated frame discarded, next frame counts afresh
        spi_frame(24'hC8FFFF, 20, rx);
        check(code_o[0 +: 16] == 16'h8888, "R10 truncated frame discarded",
              code_o[0 +: 16], 16'h8888);
        spi_frame(24'hC84000, 24, rx);
        check(code_o[0 +: 16] == 16'h4000, "R10 frame after truncation",
              code_o[0 +: 16], 16'h4000);

        // R8 reply frame MOSI ignored
        spi_frame(rb_req(3'd0, 6'h09), 24, rx);
        spi_frame(24'hC94444, 24, rx);
        check(rx == 24'h0, "R8 reply of ch1 code", rx, 0);
        check(code_o[1*16 +: 16] == 16'h0000, "R8 reply frame not decoded",
              code_o[1*16 +: 16], 0);
        spi_frame(24'hC94444, 24, rx);
        check(rx == 24'h0 && code_o[1*16 +: 16] == 16'h4444, "R7 reply consumed, R1 write decoded",
              {rx, code_o[1*16 +: 16]}, {24'h0, 16'h4444});

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule